// File: doc/BRIEF.md
# DRAM Address-Map Configuration Matcher

This block chooses an address-map configuration for a DRAM channel once the memory geometry is known. Its inputs are the detected column count, the detected row count, a bus-width code and the scheduling pattern that is wanted. It walks a fixed table of sixteen candidate configurations and reports the index of the first entry that fits the pattern's match rule. If no entry fits, it raises a miss flag instead.

A start pulse begins the walk. One table entry is examined per clock, in ascending order. A single-cycle done pulse marks the end of the walk. The result stays on the outputs until the next accepted start, so the surrounding boot logic can read it whenever it suits.

Top module: `amap_matcher`

## Requirements
- R1: After reset, busy, done and miss are low and the index output reads 0.
- R2: Start is accepted only while idle. A start raised during a walk has no effect on that walk's result or timing.
- R3: Entries are examined one per clock. If start is sampled at rising edge 0, done is high for exactly one cycle, following edge k+1. Here k is the matching index, or 15 when nothing matches. Busy is high from edge 1 until done rises.
- R4: Pattern codes are 0 = column-bank-row-device, 1 = column-row-bank-device, 2 = column-bank-device-row, and 3 = no table entry.
- R4 (table contents): Each table entry holds (rows, columns). Code-0 entries are 0:(13,10), 1:(14,10), 2:(15,10), 3:(16,10), 4:(14,11), 5:(15,11), 6:(16,11), 7:(13,9), 8:(14,9), 9:(15,9), 10:(16,9). Code-1 entries are 11:(15,10), 12:(14,11), 13:(13,10). Code-2 entries are 14:(16,10) and 15:(16,9).
- R4 (type filter): Entries of another pattern type are skipped.
- R5: Under pattern 0, an entry matches only when both its columns and its rows equal the inputs.
- R6: Under pattern 1, an entry matches when its columns are equal and its rows are no greater than the detected rows.
- R7: Under pattern 2, an entry matches when its columns are equal. It also matches when its columns are no greater than the detected columns and its rows are equal.
- R8: Bus-width code 2 means a 32-bit bus, and columns are compared as given. For any other code, one is subtracted from the detected columns before the compare, saturating at 0.
- R9: When several entries match, the lowest index wins.
- R10: When no entry matches, miss is set and the index reads 0.
- R11: Index and miss hold their values until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (honoured when idle) |
| pat_i | input | 2 | Requested pattern code |
| col_i | input | COL_W | Detected column count |
| row_i | input | ROW_W | Detected row count |
| bw_i | input | 2 | Bus-width code (2 = 32-bit) |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| miss_o | output | 1 | No entry matched |
| idx_o | output | IDX_W | Index of the first matching entry |

## Verification
The hardest situation to reach from the ports is a second start arriving mid-walk. The stimulus raises start again two cycles into a long walk, with different geometry on the inputs. The scoreboard then expects only the first walk's result, with its original latency. Any extra done pulse is flagged as unexpected.

The rule cases are steered so that earlier entries nearly match but fail. Examples are the row lower bound of pattern 1 and the wider-columns branch of pattern 2. This forces the walk past them, which tests first-match ordering and done latency at many table positions, including a full sixteen-cycle miss.

// File: rtl/amap_pkg.sv
package amap_pkg;

    localparam int N_ENTRIES = 16;
    localparam int TBL_ROW_W = 5;
    localparam int TBL_COL_W = 4;

    typedef enum logic [1:0] {
        PAT_CBRD = 2'd0,
        PAT_CRBD = 2'd1,
        PAT_CBDR = 2'd2,
        PAT_NONE = 2'd3
    } pat_e;

    typedef struct packed {
        pat_e                 kind;
        logic [TBL_ROW_W-1:0] rows;
        logic [TBL_COL_W-1:0] cols;
    } entry_t;

    function automatic entry_t mk(input pat_e k, input int r, input int c);
        entry_t e;
        e.kind = k;
        e.rows = TBL_ROW_W'(r);
        e.cols = TBL_COL_W'(c);
        return e;
    endfunction

    // Candidate table; order is the search priority.
    function automatic entry_t amap_entry(input int i);
        case (i)
            0:       return mk(PAT_CBRD, 13, 10);
            1:       return mk(PAT_CBRD, 14, 10);
            2:       return mk(PAT_CBRD, 15, 10);
            3:       return mk(PAT_CBRD, 16, 10);
            4:       return mk(PAT_CBRD, 14, 11);
            5:       return mk(PAT_CBRD, 15, 11);
            6:       return mk(PAT_CBRD, 16, 11);
            7:       return mk(PAT_CBRD, 13, 9);
            8:       return mk(PAT_CBRD, 14, 9);
            9:       return mk(PAT_CBRD, 15, 9);
            10:      return mk(PAT_CBRD, 16, 9);
            11:      return mk(PAT_CRBD, 15, 10);
            12:      return mk(PAT_CRBD, 14, 11);
            13:      return mk(PAT_CRBD, 13, 10);
            14:      return mk(PAT_CBDR, 16, 10);
            15:      return mk(PAT_CBDR, 16, 9);
            default: return mk(PAT_NONE, 0, 0);
        endcase
    endfunction

endpackage

// File: rtl/amap_entry_rom.sv
module amap_entry_rom
    import amap_pkg::*;
#(
    parameter int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic [IDX_W-1:0] sel_i,
    output entry_t           ent_o
);
    entry_t tbl [N_ENTRIES];

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_tbl
        assign tbl[g] = amap_entry(g);
    end

    assign ent_o = tbl[sel_i];
endmodule

// File: rtl/amap_rule.sv
module amap_rule
    import amap_pkg::*;
#(
    parameter int COL_W = TBL_COL_W,
    parameter int ROW_W = TBL_ROW_W
) (
    input  pat_e             want_i,
    input  entry_t           ent_i,
    input  logic [COL_W-1:0] cols_i,
    input  logic [ROW_W-1:0] rows_i,
    output logic             hit_o
);
    logic [COL_W-1:0] ec;
    logic [ROW_W-1:0] er;

    always_comb begin
        ec    = COL_W'(ent_i.cols);
        er    = ROW_W'(ent_i.rows);
        hit_o = 1'b0;
        if (ent_i.kind == want_i) begin
            case (want_i)
                PAT_CBRD: hit_o = (ec == cols_i) && (er == rows_i);
                PAT_CRBD: hit_o = (ec == cols_i) && (er <= rows_i);
                PAT_CBDR: hit_o = (ec == cols_i) || ((ec <= cols_i) && (er == rows_i));
                default:  hit_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/amap_matcher.sv
module amap_matcher
    import amap_pkg::*;
#(
    parameter int COL_W     = TBL_COL_W,
    parameter int ROW_W     = TBL_ROW_W,
    parameter int WIDE_CODE = 2,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       pat_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [1:0]       bw_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             miss_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] cur;
        logic [COL_W-1:0] cols;
        logic [ROW_W-1:0] rows;
        pat_e             kind;
        logic             done;
        logic             miss;
        logic [IDX_W-1:0] idx;
    } st_t;

    st_t              st_q, st_d;
    entry_t           ent;
    logic             hit;
    logic [COL_W-1:0] cols_adj;

    amap_entry_rom #(.IDX_W(IDX_W)) u_rom (
        .sel_i (st_q.cur),
        .ent_o (ent)
    );

    amap_rule #(.COL_W(COL_W), .ROW_W(ROW_W)) u_rule (
        .want_i (st_q.kind),
        .ent_i  (ent),
        .cols_i (st_q.cols),
        .rows_i (st_q.rows),
        .hit_o  (hit)
    );

    // Narrow bus consumes one column bit; saturate at zero.
    always_comb begin
        cols_adj = col_i;
        if ((bw_i != 2'(WIDE_CODE)) && (col_i != '0))
            cols_adj = col_i - COL_W'(1);
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.cur  = '0;
                st_d.cols = cols_adj;
                st_d.rows = row_i;
                st_d.kind = pat_e'(pat_i);
                st_d.idx  = '0;
                st_d.miss = 1'b0;
            end
        end else if (hit) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.idx  = st_q.cur;
        end else if (st_q.cur == LAST) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.miss = 1'b1;
        end else begin
            st_d.cur = st_q.cur + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= PAT_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign miss_o = st_q.miss;
    assign idx_o  = st_q.idx;

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_miss_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |-> (idx_o == '0));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && !busy_o) |=> (done_o || ($stable(idx_o) && $stable(miss_o))));
endmodule

// File: tb/test_amap_matcher.sv
`timescale 1ns/1ps
module test_amap_matcher;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] pat = '0;
    logic [3:0] col = '0;
    logic [4:0] row = '0;
    logic [1:0] bw = 2'd2;
    logic       busy, done, miss;
    logic [3:0] idx;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        int    idx;
        bit    miss;
        int    lat;
        int    s;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    amap_matcher i_amap_matcher (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pat_i(pat),
        .col_i(col), .row_i(row), .bw_i(bw),
        .busy_o(busy), .done_o(done), .miss_o(miss), .idx_o(idx)
    );

    // Reference table from R4: kind, rows, cols
    int t_k [16] = '{0,0,0,0,0,0,0,0,0,0,0,1,1,1,2,2};
    int t_r [16] = '{13,14,15,16,14,15,16,13,14,15,16,15,14,13,16,16};
    int t_c [16] = '{10,10,10,10,11,11,11,9,9,9,9,10,11,10,10,9};

    function automatic exp_t model(input int k, input int c, input int r,
                                   input int w, input string tag);
        exp_t e;
        int ca;
        ca = (w == 2) ? c : ((c > 0) ? c - 1 : 0);
        e.idx = 0; e.miss = 1; e.lat = 17; e.s = 0; e.tag = tag;
        for (int i = 0; i < 16; i++) begin
            bit m;
            m = 0;
            if (t_k[i] == k) begin
                if (k == 0) m = (t_c[i] == ca) && (t_r[i] == r);
                if (k == 1) m = (t_c[i] == ca) && (t_r[i] <= r);
                if (k == 2) m = (t_c[i] == ca) || ((t_c[i] <= ca) && (t_r[i] == r));
            end
            if (m) begin
                e.idx = i; e.miss = 0; e.lat = i + 2;
                break;
            end
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    task automatic launch(input int k, input int c, input int r, input int w,
                          input string tag);
        exp_t e;
        @(negedge clk);
        pat = 2'(k); col = 4'(c); row = 5'(r); bw = 2'(w); start = 1'b1;
        e = model(k, c, r, w, tag);
        e.s = cyc;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input int k, input int c, input int r, input int w,
                       input string tag);
        launch(k, c, r, w, tag);
        wait_done();
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(0, "R2 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(idx == 4'(e.idx), {e.tag, " idx"}, idx, e.idx);
                check(miss == e.miss, {e.tag, " miss"}, miss, e.miss);
                check((cyc - e.s) == e.lat, {e.tag, " R3 latency"}, cyc - e.s, e.lat);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !miss && idx == 0, "R1 reset state",
              {busy, done, miss}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && idx == 0, "R1 after release", idx, 0);

        run(0, 10, 13, 2, "R5 R9 cbrd first");
        run(0, 9, 16, 2, "R5 cbrd 9x16");
        run(0, 11, 16, 2, "R5 cbrd 11x16");
        run(0, 11, 13, 2, "R5 R10 cbrd miss");
        run(1, 10, 16, 2, "R6 crbd rows above");
        run(1, 10, 14, 2, "R6 crbd skip 11");
        run(1, 11, 13, 2, "R6 R10 crbd miss");
        run(1, 11, 14, 2, "R6 crbd equal rows");
        run(2, 10, 12, 2, "R7 cbdr cols equal");
        run(2, 9, 12, 2, "R7 cbdr last entry");
        run(2, 11, 16, 2, "R7 cbdr wider cols");
        run(2, 11, 15, 2, "R7 R10 cbdr miss");
        run(3, 10, 13, 2, "R4 type none miss");
        run(0, 11, 13, 1, "R8 narrow 11->10");
        run(0, 10, 13, 0, "R8 narrow 10->9");
        run(2, 0, 16, 3, "R8 narrow saturate");

        // R2: second start mid-walk is ignored
        launch(2, 9, 12, 2, "R2 busy start ignored");
        @(negedge clk);
        pat = 2'd0; col = 4'd10; row = 5'd13; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();

        // R11: outputs hold with changing inputs and no start
        run(1, 10, 14, 2, "R11 setup");
        pat = 2'd0; col = 4'd10; row = 5'd13; bw = 2'd1;
        repeat (5) @(negedge clk);
        check(idx == 4'd13 && !miss && !done && !busy, "R11 hold", idx, 13);
        run(0, 11, 13, 2, "R11 miss setup");
        repeat (4) @(negedge clk);
        check(miss && idx == 0 && !done, "R11 R10 miss hold", miss, 1);
        launch(0, 10, 13, 2, "R11 clear on start");
        check(!miss && idx == 0 && busy, "R11 cleared by start", miss, 0);
        wait_done();

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R3 pending results", sb.size(), 0);
        finish_run();
    end
endmodule